// File: doc/BRIEF.md
# Interrupt Request Acceptance Controller

This block sits next to a small CPU's sequencer. It decides which interrupt the CPU should service next, and when. It takes a set of level-sensitive maskable request lines, one asynchronous non-maskable request pin, the global interrupt enable and a slot strobe from the CPU. The slot strobe means "an interrupt may be taken at this boundary." On a clock edge where the slot strobe is high and something is eligible, the block accepts the highest-ranked candidate. One cycle later it reports that candidate's vector index together with a single-cycle acknowledge.

The vector table holds 16, 32 or 64 entries. The top entry belongs to reset and the entry just below it belongs to the non-maskable request. All lower entries map one-to-one onto the maskable lines, so there are two fewer lines than vectors. A higher index always outranks a lower one.

The non-maskable pin passes through an optional two-stage synchronizer. An edge detector then watches it, and a configuration input selects which edge counts. Each detected edge leaves a pending flag, and accepting the non-maskable vector clears that flag. Fetching the vector, saving context and CPU sequencing are outside this block.

Top module: `irq_accept_ctrl`

## Requirements
- R1: Immediately after reset, `ackValid` is 0, `irqAck` is all zeros, and `reqPending` is 1 because the reset vector is pending.
- R2: The first acceptance after reset reports vector index NUM_VECTORS-1 (15 by default) whatever the state of `gie` and the request lines. `irqAck` stays zero for it.
- R3: A maskable line is eligible only while `gie` is 1. With `gie` at 0 and nothing else pending, no acceptance happens and `reqPending` is 0.
- R4: Accepting maskable line i reports vector index i and drives `irqAck` one-hot, with only bit i (the same position as request line i) set.
- R5: A pending non-maskable request (vector NUM_VECTORS-2, 14 by default) outranks every maskable line. Among several asserted maskable lines, the highest index wins.
- R6: A pending non-maskable request is accepted even when `gie` is 0. `irqAck` stays zero for it.
- R7: Each detected non-maskable edge is accepted once. Acceptance clears the pending flag, and holding the pin at its new level does not raise a new request.
- R8: With `nmiFallSel` at 0 only a rising edge of `nmiPin` counts, and with it at 1 only a falling edge counts. The other edge leaves `reqPending` unchanged.
- R9: `ackValid` and `irqAck` last exactly one cycle. In the cycle right after an acceptance no new acceptance is made, even if `acceptEn` stays high.
- R10: While `acceptEn` is 0 nothing is accepted, and pending requests (including a detected non-maskable edge) are kept.
- R11: The acknowledge and the vector index appear in the cycle that follows the clock edge at which `acceptEn` was sampled high with a candidate eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_VECTORS-2 | Maskable request lines, level sensitive, bit i maps to vector i |
| gie | input | 1 | Global interrupt enable for the maskable lines |
| nmiPin | input | 1 | Asynchronous non-maskable request pin |
| nmiFallSel | input | 1 | Edge select for the non-maskable pin: 0 rising, 1 falling |
| acceptEn | input | 1 | CPU boundary strobe: an interrupt may be accepted at this edge |
| reqPending | output | 1 | Some candidate is eligible at this moment |
| ackValid | output | 1 | One-cycle strobe: a request was accepted, `vecIdx` is valid |
| vecIdx | output | $clog2(NUM_VECTORS) | Vector index of the accepted request |
| irqAck | output | NUM_VECTORS-2 | One-hot acknowledge of the accepted maskable line |

## Verification
The assertions rely on three conditions about the inputs. The non-maskable pin must sit at its inactive level through reset. The edge select must not change while the pin is at the level that would make the change look like an edge. Pin pulses must be wide enough to cross the synchronizer. The stimulus keeps the pin low during and after reset and changes the edge select only while the pin is low. It holds every pin level for several cycles and drives the maskable lines one-hot, except in the single ranking test that deliberately asserts two lines. All inputs change half a cycle away from the sampling edge, so the synchronizer and the acceptance logic always see settled values.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic take;    // accept the current winner at this edge
    logic clrNmi;  // the winner is the non-maskable vector
    logic clrRst;  // the winner is the reset vector
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
  parameter bit SYNC_EN = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic nmiPin,
  input  logic fallSel,
  output logic nmiEdge
);

  logic nmiSync;
  logic nmiPrev;

  generate
    if (SYNC_EN) begin : g_sync
      logic stage1;
      logic stage2;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= nmiPin;
          stage2 <= stage1;
        end
      end
      assign nmiSync = stage2;
    end else begin : g_nosync
      assign nmiSync = nmiPin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPrev <= 1'b0;
    else       nmiPrev <= nmiSync;
  end

  always_comb begin
    if (fallSel) nmiEdge = nmiPrev & ~nmiSync;
    else         nmiEdge = nmiSync & ~nmiPrev;
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_accept_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         nmiEdge,
  input  logic         acceptEn,
  input  logic         winValid,
  input  logic         ackValid,
  output logic         nmiPending,
  output logic         rstPending,
  output ctrlStrobes_t strobes
);

  // No acceptance in the cycle carrying an acknowledge: keeps it one cycle wide.
  always_comb begin
    strobes.take   = acceptEn & winValid & ~ackValid;
    strobes.clrRst = strobes.take & rstPending;
    strobes.clrNmi = strobes.take & nmiPending & ~rstPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPending <= 1'b1;
      nmiPending <= 1'b0;
    end else begin
      if (strobes.clrRst) rstPending <= 1'b0;
      // A fresh edge in the clearing cycle wins over the clear.
      nmiPending <= nmiEdge | (nmiPending & ~strobes.clrNmi);
    end
  end

  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !acceptEn |=> !ackValid);  // R10

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !acceptEn) |=> nmiPending);  // R10

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !rstPending |=> !rstPending);  // R2

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_accept_pkg::*;
#(
  parameter int NV   = 16,
  parameter int IRQW = NV - 2,
  parameter int VIW  = $clog2(NV)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IRQW-1:0] irqReq,
  input  logic            gie,
  input  logic            nmiPending,
  input  logic            rstPending,
  input  ctrlStrobes_t    strobes,
  output logic            winValid,
  output logic            ackValid,
  output logic [VIW-1:0]  vecIdx,
  output logic [IRQW-1:0] irqAck
);

  localparam logic [VIW-1:0] NMI_IDX = VIW'(NV - 2);
  localparam logic [VIW-1:0] RST_IDX = VIW'(NV - 1);

  logic [VIW-1:0]  winIdx;
  logic [IRQW-1:0] ackNext;

  // Ascending scan: the last hit is the highest index.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    if (gie) begin
      for (int i = 0; i < IRQW; i++) begin
        if (irqReq[i]) begin
          winValid = 1'b1;
          winIdx   = VIW'(i);
        end
      end
    end
    if (nmiPending) begin
      winValid = 1'b1;
      winIdx   = NMI_IDX;
    end
    if (rstPending) begin
      winValid = 1'b1;
      winIdx   = RST_IDX;
    end
  end

  always_comb begin
    for (int i = 0; i < IRQW; i++) ackNext[i] = (winIdx == VIW'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      vecIdx   <= '0;
      irqAck   <= '0;
    end else begin
      ackValid <= strobes.take;
      irqAck   <= strobes.take ? ackNext : '0;
      if (strobes.take) vecIdx <= winIdx;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);  // R9

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck));  // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!gie && !nmiPending && !rstPending) |=> !ackValid);  // R3

  AST_SPECIAL_NO_LINE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && vecIdx >= VIW'(NV - 2)) |-> (irqAck == '0));  // R6

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int NUM_VECTORS = 16,
  parameter bit SYNC_NMI    = 1'b1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_VECTORS-3:0]         irqReq,
  input  logic                           gie,
  input  logic                           nmiPin,
  input  logic                           nmiFallSel,
  input  logic                           acceptEn,
  output logic                           reqPending,
  output logic                           ackValid,
  output logic [$clog2(NUM_VECTORS)-1:0] vecIdx,
  output logic [NUM_VECTORS-3:0]         irqAck
);

  localparam int IRQW = NUM_VECTORS - 2;
  localparam int VIW  = $clog2(NUM_VECTORS);

  logic         nmiEdge;
  logic         nmiPending;
  logic         rstPending;
  logic         winValid;
  ctrlStrobes_t strobes;

  irq_nmi_detect #(.SYNC_EN(SYNC_NMI)) i_nmi (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .fallSel(nmiFallSel),
    .nmiEdge(nmiEdge)
  );

  irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .nmiEdge(nmiEdge), .acceptEn(acceptEn),
    .winValid(winValid), .ackValid(ackValid), .nmiPending(nmiPending),
    .rstPending(rstPending), .strobes(strobes)
  );

  irq_datapath #(.NV(NUM_VECTORS), .IRQW(IRQW), .VIW(VIW)) i_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .gie(gie),
    .nmiPending(nmiPending), .rstPending(rstPending), .strobes(strobes),
    .winValid(winValid), .ackValid(ackValid), .vecIdx(vecIdx), .irqAck(irqAck)
  );

  assign reqPending = winValid;

endmodule

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;

  localparam int NV   = 16;
  localparam int IRQW = NV - 2;
  localparam int VIW  = $clog2(NV);
  localparam int NTBL = 8;

  // {gie, hasLine, line[5:0], expValid, expVec[5:0]}
  localparam logic [14:0] TBL [0:NTBL-1] = '{
    {1'b1, 1'b1, 6'd0,  1'b1, 6'd0},
    {1'b1, 1'b1, 6'd13, 1'b1, 6'd13},
    {1'b1, 1'b1, 6'd7,  1'b1, 6'd7},
    {1'b0, 1'b1, 6'd5,  1'b0, 6'd0},
    {1'b1, 1'b0, 6'd0,  1'b0, 6'd0},
    {1'b0, 1'b0, 6'd0,  1'b0, 6'd0},
    {1'b1, 1'b1, 6'd1,  1'b1, 6'd1},
    {1'b0, 1'b1, 6'd13, 1'b0, 6'd0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [IRQW-1:0] irqReq = '0;
  logic            gie = 1'b0;
  logic            nmiPin = 1'b0;
  logic            nmiFallSel = 1'b0;
  logic            acceptEn = 1'b0;
  logic            reqPending;
  logic            ackValid;
  logic [VIW-1:0]  vecIdx;
  logic [IRQW-1:0] irqAck;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  irq_accept_ctrl #(.NUM_VECTORS(NV), .SYNC_NMI(1'b1)) i_irq_accept_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .gie(gie), .nmiPin(nmiPin),
    .nmiFallSel(nmiFallSel), .acceptEn(acceptEn), .reqPending(reqPending),
    .ackValid(ackValid), .vecIdx(vecIdx), .irqAck(irqAck)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One-cycle accept slot; results sampled at the next falling edge.
  task automatic slot(output logic v, output logic [VIW-1:0] idx, output logic [IRQW-1:0] ack);
    @(negedge clk) acceptEn = 1'b1;
    @(negedge clk) acceptEn = 1'b0;
    v = ackValid; idx = vecIdx; ack = irqAck;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [VIW-1:0] idx;
    logic [IRQW-1:0] ack;

    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R1: reset state
    check("R1 ackValid", 32'(ackValid), 0);
    check("R1 irqAck", 32'(irqAck), 0);
    check("R1 reqPending", 32'(reqPending), 1);

    // R2: reset vector first, gie low, a line asserted
    irqReq = IRQW'(1) << 3;
    slot(v, idx, ack);
    check("R2 valid", 32'(v), 1);
    check("R2 vector", 32'(idx), NV - 1);
    check("R2 irqAck", 32'(ack), 0);
    // R9: pulse gone next cycle
    waitCycles(1);
    check("R9 pulse end", 32'(ackValid), 0);
    // R3: line masked by gie
    check("R3 masked pending", 32'(reqPending), 0);
    irqReq = '0;

    // Table of maskable patterns: R3, R4, R11
    for (int k = 0; k < NTBL; k++) begin
      logic [14:0] e;
      e = TBL[k];
      @(negedge clk);
      gie    = e[14];
      irqReq = e[13] ? (IRQW'(1) << e[12:7]) : '0;
      slot(v, idx, ack);
      check("R3 table valid", 32'(v), 32'(e[6]));
      if (e[6]) begin
        check("R4 table vector", 32'(idx), 32'(e[5:0]));
        check("R4 table onehot", 32'(ack), 32'(IRQW'(1) << e[5:0]));
      end else begin
        check("R3 table no ack", 32'(ack), 0);
      end
      @(negedge clk) irqReq = '0;
    end

    // R10: NMI edge held while no slot is offered
    gie = 1'b0;
    @(negedge clk) nmiPin = 1'b1;
    waitCycles(5);
    check("R10 no ack without slot", 32'(ackValid), 0);
    check("R10 nmi kept pending", 32'(reqPending), 1);
    // R6: NMI despite gie low
    slot(v, idx, ack);
    check("R6 nmi valid", 32'(v), 1);
    check("R6 nmi vector", 32'(idx), NV - 2);
    check("R6 nmi irqAck", 32'(ack), 0);
    // R7: level held high gives no second acceptance
    waitCycles(1);
    check("R7 pending cleared", 32'(reqPending), 0);
    slot(v, idx, ack);
    check("R7 no retrigger", 32'(v), 0);
    @(negedge clk) nmiPin = 1'b0;
    waitCycles(5);

    // R5: NMI beats a maskable line, then the line is taken
    gie = 1'b1;
    irqReq = IRQW'(1) << 13;
    @(negedge clk) nmiPin = 1'b1;
    waitCycles(5);
    slot(v, idx, ack);
    check("R5 nmi first", 32'(idx), NV - 2);
    slot(v, idx, ack);
    check("R5 line next", 32'(idx), 13);
    check("R5 line ack", 32'(ack), 32'(IRQW'(1) << 13));
    // R5: two lines, higher index wins
    @(negedge clk) irqReq = (IRQW'(1) << 2) | (IRQW'(1) << 9);
    slot(v, idx, ack);
    check("R5 rank vector", 32'(idx), 9);
    check("R5 rank ack", 32'(ack), 32'(IRQW'(1) << 9));
    @(negedge clk) begin irqReq = '0; nmiPin = 1'b0; end
    waitCycles(5);

    // R8: falling-edge select ignores a rising edge
    gie = 1'b0;
    nmiFallSel = 1'b1;
    waitCycles(2);
    @(negedge clk) nmiPin = 1'b1;
    waitCycles(5);
    check("R8 rise ignored", 32'(reqPending), 0);
    @(negedge clk) nmiPin = 1'b0;
    waitCycles(5);
    check("R8 fall detected", 32'(reqPending), 1);
    slot(v, idx, ack);
    check("R8 fall vector", 32'(idx), NV - 2);
    nmiFallSel = 1'b0;
    waitCycles(3);

    // R9 / R11: slot held for three cycles with a line held high
    gie = 1'b1;
    irqReq = IRQW'(1) << 4;
    @(negedge clk) acceptEn = 1'b1;
    check("R11 not before edge", 32'(ackValid), 0);
    @(negedge clk);
    check("R11 ack after edge", 32'(ackValid), 1);
    check("R11 vector", 32'(vecIdx), 4);
    @(negedge clk);
    check("R9 gap cycle", 32'(ackValid), 0);
    check("R9 gap irqAck", 32'(irqAck), 0);
    @(negedge clk);
    check("R9 next accept", 32'(ackValid), 1);
    acceptEn = 1'b0;
    irqReq = '0;
    waitCycles(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule